// File: doc/BRIEF.md
# Atomic Compare-Exchange and Exchange-Add Execute Unit

This unit is the execute stage for two read-modify-write integer instructions, compare-and-exchange and exchange-and-add. It handles byte, word and doubleword operands. The destination is either a register or a memory location. Decode hands it the ModRM byte, the accumulator, the source register value and, for register forms, the destination register value. Effective address generation, paging and bus locking happen elsewhere. For memory forms the unit therefore only raises read and write requests over a request/ready handshake, and the address comes from outside.

When an operation ends, the unit pulses `done` for one cycle. In that cycle it presents the register writebacks (destination, source, accumulator), a six-bit arithmetic flag update and the cycle cost of the instruction. It holds `busy` high from the cycle after it accepts an operation through the `done` cycle, and it ignores `start` during that time.

Top module: `rmw_atomic_unit`

## Requirements
- R1: While reset is active, and after it, the unit is idle: `busy`, `done`, `memReq`, `memWe` and all writeback enables (`dstWe`, `srcWe`, `accWe`, `flagsWe`) are low.
- R2: A ModRM value of 0xC0 or above selects a register destination, and that operation issues no memory request. A lower ModRM value selects a memory destination. The destination is then read through the memory port before any compute, and `dstIn` is ignored.
- R3: Compare-exchange (`opKind`=0) with the sized accumulator equal to the sized destination writes the source value to the destination: `dstWe` with `dstData`=source for a register destination, or one memory write of the source for a memory destination. It does not write the accumulator.
- R4: Compare-exchange with unequal values loads the destination into the accumulator (`accWe`, `accData`). It writes neither the destination register nor memory.
- R5: Compare-exchange flags are those of accumulator minus destination at the operand width. Flag layout: bit0 carry/borrow, bit1 parity (1 when the low result byte has an even count of ones), bit2 auxiliary carry out of bit 3, bit3 zero, bit4 sign, bit5 overflow.
- R6: Exchange-add (`opKind`=1) writes destination+source to the destination and the original destination to the source register (`srcWe`, `srcData`). Flags are those of the addition, in the layout of R5.
- R7: A memory exchange-add issues exactly one read, then one write of the sum. `done` (the register writeback) comes only after the write has been accepted.
- R8: `opSize` 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. Operand bits above the width are ignored, and all writeback data is zero-extended from the width.
- R9: `cycleCount` reports six defaults: compare-exchange register/equal 6, register/unequal 7, memory/equal 8, memory/unequal 10; exchange-add register 3, memory 4.
- R10: `busy` is high from the cycle after acceptance through the `done` cycle and low after it. `done` lasts one cycle. A `start` seen while busy is ignored.
- R11: A memory request holds `memReq`, `memWe` and `memWdata` steady until `memReady` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| opKind | input | 1 | 0 compare-exchange, 1 exchange-add |
| opSize | input | 2 | Operand width select |
| modrm | input | 8 | ModRM byte; selects register or memory destination |
| accIn | input | 32 | Accumulator value |
| srcIn | input | 32 | Source register value |
| dstIn | input | 32 | Destination register value (register forms) |
| memRdata | input | 32 | Memory read data |
| memReady | input | 1 | Memory accepts the current request |
| memReq | output | 1 | Memory request valid |
| memWe | output | 1 | Request is a write |
| memWdata | output | 32 | Memory write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| dstWe | output | 1 | Destination register write |
| dstData | output | 32 | Destination register data |
| srcWe | output | 1 | Source register write |
| srcData | output | 32 | Source register data |
| accWe | output | 1 | Accumulator write |
| accData | output | 32 | Accumulator data |
| flagsWe | output | 1 | Flag update valid |
| flagsOut | output | 6 | Arithmetic flags |
| cycleCount | output | 8 | Instruction cycle cost |

## Verification
The hardest behaviour to reach from the ports is the ordering of the memory forms under back-pressure. A write must follow its read, must not occur at all on an unequal compare, and must finish before the register writeback. The bench's memory responder stretches `memReady` by zero to two cycles and logs each accepted read and write in order. It also keeps `start` asserted with unrelated operands in the cycle after acceptance, which tests that a busy unit ignores new work. A sweep over both operations, all three widths and both destination kinds uses operand pairs chosen to give carry, signed overflow, zero, equal and unequal outcomes. Inputs carry garbage above the operand width.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

  localparam int DATA_W = 32;
  localparam int FLAG_W = 6;
  localparam int CNT_W  = 8;

  localparam int F_CF = 0;
  localparam int F_PF = 1;
  localparam int F_AF = 2;
  localparam int F_ZF = 3;
  localparam int F_SF = 4;
  localparam int F_OF = 5;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_WIDE  = 2'd3
  } opSize_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_READ = 3'd1,
    ST_EXEC = 3'd2,
    ST_WRITE = 3'd3,
    ST_FIN  = 3'd4
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch operands of an accepted operation
    logic loadMem;   // latch memory read data as destination
    logic exec;      // evaluate and latch results
    logic finish;    // present writebacks
  } ctrlStrobes_t;

  function automatic logic [DATA_W-1:0] sizeMask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: sizeMask = {{(DATA_W-8){1'b0}}, 8'hFF};
      SZ_WORD: sizeMask = {{(DATA_W-16){1'b0}}, 16'hFFFF};
      default: sizeMask = {DATA_W{1'b1}};
    endcase
  endfunction

endpackage

// File: rtl/rmw_alu.sv
module rmw_alu
  import rmw_pkg::*;
(
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [1:0]        sizeSel,
  input  logic              doSub,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flags
);

  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] aM, bM;
  logic [DATA_W:0]   wide;
  logic              carryOut, signA, signB, signR;

  always_comb begin
    mask = sizeMask(sizeSel);
    aM   = opA & mask;
    bM   = opB & mask;
    if (doSub) wide = {1'b0, aM} - {1'b0, bM};
    else       wide = {1'b0, aM} + {1'b0, bM};
    result = wide[DATA_W-1:0] & mask;
  end

  // carry and sign taps move with the operand width
  always_comb begin
    case (sizeSel)
      SZ_BYTE: begin
        carryOut = wide[8];
        signA = aM[7]; signB = bM[7]; signR = result[7];
      end
      SZ_WORD: begin
        carryOut = wide[16];
        signA = aM[15]; signB = bM[15]; signR = result[15];
      end
      default: begin
        carryOut = wide[DATA_W];
        signA = aM[DATA_W-1]; signB = bM[DATA_W-1]; signR = result[DATA_W-1];
      end
    endcase
  end

  always_comb begin
    flags       = '0;
    flags[F_CF] = carryOut;
    flags[F_PF] = ~^result[7:0];
    flags[F_AF] = aM[4] ^ bM[4] ^ result[4];
    flags[F_ZF] = (result == '0);
    flags[F_SF] = signR;
    if (doSub) flags[F_OF] = (signA != signB) && (signR != signA);
    else       flags[F_OF] = (signA == signB) && (signR != signA);
  end

endmodule

// File: rtl/rmw_ctrl.sv
module rmw_ctrl
  import rmw_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [7:0]   modrm,
  input  logic         isXadd,
  input  logic         cmpEq,
  input  logic         memReady,
  output ctrlStrobes_t strobes,
  output logic         memReq,
  output logic         memWe,
  output logic         busy,
  output logic         done
);

  seqState_e state, stateNext;
  logic      isMemQ;
  logic      regForm;

  assign regForm = (modrm >= 8'hC0);

  always_comb begin
    stateNext = state;
    strobes   = '0;
    case (state)
      ST_IDLE: if (start) begin
        strobes.capture = 1'b1;
        stateNext = regForm ? ST_EXEC : ST_READ;
      end
      ST_READ: if (memReady) begin
        strobes.loadMem = 1'b1;
        stateNext = ST_EXEC;
      end
      ST_EXEC: begin
        strobes.exec = 1'b1;
        stateNext = (isMemQ && (isXadd || cmpEq)) ? ST_WRITE : ST_FIN;
      end
      ST_WRITE: if (memReady) stateNext = ST_FIN;
      ST_FIN: begin
        strobes.finish = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      isMemQ <= 1'b0;
    end else begin
      state <= stateNext;
      if (strobes.capture) isMemQ <= !regForm;
    end
  end

  assign memReq = (state == ST_READ) || (state == ST_WRITE);
  assign memWe  = (state == ST_WRITE);
  assign busy   = (state != ST_IDLE);
  assign done   = (state == ST_FIN);

  // R10: completion happens inside the busy window
  a_r10_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  // R10: a single completion pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11: outstanding request is held
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && !memReady) |=> (memReq && $stable(memWe)));

  // R2: a register-destination operation never touches memory
  a_r2_reg_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !isMemQ) |-> !memReq);

  // R4: an unequal compare never proceeds to a memory write
  a_r4_ne_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && !isXadd && !cmpEq) |=> !memWe);

endmodule

// File: rtl/rmw_datapath.sv
module rmw_datapath
  import rmw_pkg::*;
#(
  parameter int CYC_CX_REG_EQ = 6,
  parameter int CYC_CX_REG_NE = 7,
  parameter int CYC_CX_MEM_EQ = 8,
  parameter int CYC_CX_MEM_NE = 10,
  parameter int CYC_XA_REG    = 3,
  parameter int CYC_XA_MEM    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobes_t      strobes,
  input  logic              kindIn,
  input  logic [1:0]        sizeIn,
  input  logic [7:0]        modrm,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] srcIn,
  input  logic [DATA_W-1:0] dstIn,
  input  logic [DATA_W-1:0] memRdata,
  output logic              isXadd,
  output logic              cmpEq,
  output logic [DATA_W-1:0] memWdata,
  output logic              dstWe,
  output logic [DATA_W-1:0] dstData,
  output logic              srcWe,
  output logic [DATA_W-1:0] srcData,
  output logic              accWe,
  output logic [DATA_W-1:0] accData,
  output logic              flagsWe,
  output logic [FLAG_W-1:0] flagsOut,
  output logic [CNT_W-1:0]  cycleCount
);

  logic              kindQ, isMemQ, eqQ;
  logic [1:0]        sizeQ;
  logic [DATA_W-1:0] accQ, srcQ, dstQ;
  logic [DATA_W-1:0] resDst, resSrc, resAcc;
  logic [FLAG_W-1:0] flagsQ;
  logic [CNT_W-1:0]  cycQ, cycSel;
  logic [DATA_W-1:0] inMask, qMask;
  logic [DATA_W-1:0] aluA, aluB, aluRes;
  logic [FLAG_W-1:0] aluFlags;

  assign inMask = sizeMask(sizeIn);
  assign qMask  = sizeMask(sizeQ);
  assign isXadd = kindQ;
  assign cmpEq  = ((accQ & qMask) == (dstQ & qMask));

  // exchange-add: dst + src ; compare-exchange: acc - dst
  assign aluA = kindQ ? dstQ : accQ;
  assign aluB = kindQ ? srcQ : dstQ;

  rmw_alu alu_i (
    .opA    (aluA),
    .opB    (aluB),
    .sizeSel(sizeQ),
    .doSub  (!kindQ),
    .result (aluRes),
    .flags  (aluFlags)
  );

  always_comb begin
    if (kindQ) cycSel = isMemQ ? CNT_W'(CYC_XA_MEM) : CNT_W'(CYC_XA_REG);
    else if (isMemQ) cycSel = cmpEq ? CNT_W'(CYC_CX_MEM_EQ) : CNT_W'(CYC_CX_MEM_NE);
    else cycSel = cmpEq ? CNT_W'(CYC_CX_REG_EQ) : CNT_W'(CYC_CX_REG_NE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kindQ  <= 1'b0;
      isMemQ <= 1'b0;
      sizeQ  <= SZ_BYTE;
      accQ   <= '0;
      srcQ   <= '0;
      dstQ   <= '0;
      resDst <= '0;
      resSrc <= '0;
      resAcc <= '0;
      flagsQ <= '0;
      eqQ    <= 1'b0;
      cycQ   <= '0;
    end else begin
      if (strobes.capture) begin
        kindQ  <= kindIn;
        isMemQ <= (modrm < 8'hC0);
        sizeQ  <= sizeIn;
        accQ   <= accIn & inMask;
        srcQ   <= srcIn & inMask;
        dstQ   <= dstIn & inMask;
      end
      if (strobes.loadMem) dstQ <= memRdata & qMask;
      if (strobes.exec) begin
        resDst <= kindQ ? aluRes : srcQ;
        resSrc <= dstQ;
        resAcc <= dstQ;
        flagsQ <= aluFlags;
        eqQ    <= cmpEq;
        cycQ   <= cycSel;
      end
    end
  end

  assign memWdata   = resDst;
  assign dstWe      = strobes.finish && !isMemQ && (kindQ || eqQ);
  assign dstData    = resDst;
  assign srcWe      = strobes.finish && kindQ;
  assign srcData    = resSrc;
  assign accWe      = strobes.finish && !kindQ && !eqQ;
  assign accData    = resAcc;
  assign flagsWe    = strobes.finish;
  assign flagsOut   = flagsQ;
  assign cycleCount = cycQ;

  // R8: byte-sized writebacks carry nothing above bit 7
  a_r8_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.finish && sizeQ == SZ_BYTE) |-> (dstData[DATA_W-1:8] == '0 && srcData[DATA_W-1:8] == '0));

  // R3: an equal compare reports a zero difference
  a_r3_eq_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.finish && !kindQ && eqQ) |-> flagsOut[F_ZF]);

  // R5: an unequal compare never reports zero
  a_r5_ne_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.finish && !kindQ && !eqQ) |-> !flagsOut[F_ZF]);

endmodule

// File: rtl/rmw_atomic_unit.sv
module rmw_atomic_unit
  import rmw_pkg::*;
#(
  parameter int CYC_CX_REG_EQ = 6,
  parameter int CYC_CX_REG_NE = 7,
  parameter int CYC_CX_MEM_EQ = 8,
  parameter int CYC_CX_MEM_NE = 10,
  parameter int CYC_XA_REG    = 3,
  parameter int CYC_XA_MEM    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        opKind,
  input  logic [1:0]  opSize,
  input  logic [7:0]  modrm,
  input  logic [31:0] accIn,
  input  logic [31:0] srcIn,
  input  logic [31:0] dstIn,
  input  logic [31:0] memRdata,
  input  logic        memReady,
  output logic        memReq,
  output logic        memWe,
  output logic [31:0] memWdata,
  output logic        busy,
  output logic        done,
  output logic        dstWe,
  output logic [31:0] dstData,
  output logic        srcWe,
  output logic [31:0] srcData,
  output logic        accWe,
  output logic [31:0] accData,
  output logic        flagsWe,
  output logic [5:0]  flagsOut,
  output logic [7:0]  cycleCount
);

  ctrlStrobes_t strobes;
  logic         isXadd, cmpEq;

  rmw_ctrl ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .modrm   (modrm),
    .isXadd  (isXadd),
    .cmpEq   (cmpEq),
    .memReady(memReady),
    .strobes (strobes),
    .memReq  (memReq),
    .memWe   (memWe),
    .busy    (busy),
    .done    (done)
  );

  rmw_datapath #(
    .CYC_CX_REG_EQ(CYC_CX_REG_EQ),
    .CYC_CX_REG_NE(CYC_CX_REG_NE),
    .CYC_CX_MEM_EQ(CYC_CX_MEM_EQ),
    .CYC_CX_MEM_NE(CYC_CX_MEM_NE),
    .CYC_XA_REG   (CYC_XA_REG),
    .CYC_XA_MEM   (CYC_XA_MEM)
  ) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .kindIn    (opKind),
    .sizeIn    (opSize),
    .modrm     (modrm),
    .accIn     (accIn),
    .srcIn     (srcIn),
    .dstIn     (dstIn),
    .memRdata  (memRdata),
    .isXadd    (isXadd),
    .cmpEq     (cmpEq),
    .memWdata  (memWdata),
    .dstWe     (dstWe),
    .dstData   (dstData),
    .srcWe     (srcWe),
    .srcData   (srcData),
    .accWe     (accWe),
    .accData   (accData),
    .flagsWe   (flagsWe),
    .flagsOut  (flagsOut),
    .cycleCount(cycleCount)
  );

  // R4: accumulator load excludes both exchange writebacks
  a_r4_acc_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    accWe |-> (!dstWe && !srcWe));

  // R6: exchange-add always returns the old destination
  a_r6_src_with_flags: assert property (@(posedge clk) disable iff (!rst_n)
    srcWe |-> (flagsWe && !accWe));

  // R11: write data is steady while a write waits
  a_r11_wdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (memWe && !memReady) |=> $stable(memWdata));

  // R1: nothing is written back outside a completion
  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !(dstWe || srcWe || accWe || flagsWe));

endmodule

// File: tb/rmw_atomic_unit_tb_top.sv
module rmw_atomic_unit_tb_top;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, start, opKind, memReady;
  logic [1:0]  opSize;
  logic [7:0]  modrm;
  logic [31:0] accIn, srcIn, dstIn, memRdata;
  logic        memReq, memWe, busy, done;
  logic [31:0] memWdata, dstData, srcData, accData;
  logic        dstWe, srcWe, accWe, flagsWe;
  logic [5:0]  flagsOut;
  logic [7:0]  cycleCount;

  rmw_atomic_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .opKind(opKind), .opSize(opSize),
    .modrm(modrm), .accIn(accIn), .srcIn(srcIn), .dstIn(dstIn),
    .memRdata(memRdata), .memReady(memReady), .memReq(memReq), .memWe(memWe),
    .memWdata(memWdata), .busy(busy), .done(done), .dstWe(dstWe),
    .dstData(dstData), .srcWe(srcWe), .srcData(srcData), .accWe(accWe),
    .accData(accData), .flagsWe(flagsWe), .flagsOut(flagsOut),
    .cycleCount(cycleCount)
  );

  int vecCount = 0;
  int failCount = 0;

  // memory responder state
  logic [31:0] memWord = '0;
  int          memLat = 0;
  int          waitCnt = 0;
  int          readCount = 0;
  int          writeCount = 0;
  logic [31:0] lastWrite = '0;
  bit          orderBad = 1'b0;
  logic [31:0] lfsr = 32'hACE1_1357;

  assign memRdata = memWord;

  initial memReady = 1'b0;
  always @(negedge clk) begin
    if (!memReq || memReady) begin
      memReady = 1'b0;
      waitCnt  = 0;
    end else if (waitCnt >= memLat) begin
      memReady = 1'b1;
      if (memWe) begin
        writeCount++;
        lastWrite = memWdata;
        if (readCount == 0) orderBad = 1'b1;
      end else begin
        readCount++;
        if (writeCount != 0) orderBad = 1'b1;
      end
    end else begin
      waitCnt++;
    end
  end

  function automatic logic [31:0] nextRand(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // reference flags: bit0 C, 1 P, 2 A, 3 Z, 4 S, 5 O
  function automatic logic [5:0] refFlags(input bit isSub, input longint unsigned a,
                                          input longint unsigned b, input int n);
    longint unsigned m, r, res;
    bit sa, sb, sr;
    logic [5:0] f;
    m   = (64'd1 << n) - 1;
    r   = isSub ? (a - b) : (a + b);
    res = r & m;
    sa  = a[n-1]; sb = b[n-1]; sr = res[n-1];
    f[0] = r[n];
    f[1] = ~^res[7:0];
    f[2] = a[4] ^ b[4] ^ res[4];
    f[3] = (res == 0);
    f[4] = sr;
    f[5] = isSub ? ((sa != sb) && (sr != sa)) : ((sa == sb) && (sr != sa));
    return f;
  endfunction

  task automatic runOp(input bit kind, input logic [1:0] sz, input bit isMem,
                       input logic [31:0] a, input logic [31:0] s, input logic [31:0] d,
                       input logic [7:0] rm, input logic [31:0] junk);
    int n;
    logic [31:0] m, expDst, expAcc;
    logic [5:0]  expFlags;
    logic [7:0]  expCyc;
    bit eq, seen;
    n = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    m = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1);
    a &= m; s &= m; d &= m;
    eq = (a == d);
    if (kind) begin
      expDst   = (d + s) & m;
      expFlags = refFlags(1'b0, 64'(d), 64'(s), n);
      expCyc   = isMem ? 8'd4 : 8'd3;
    end else begin
      expDst   = s;
      expFlags = refFlags(1'b1, 64'(a), 64'(d), n);
      expCyc   = isMem ? (eq ? 8'd8 : 8'd10) : (eq ? 8'd6 : 8'd7);
    end
    expAcc = d;

    @(negedge clk);
    readCount = 0; writeCount = 0; orderBad = 1'b0; lastWrite = '0;
    opKind = kind; opSize = sz; modrm = rm;
    accIn = a | (junk & ~m);
    srcIn = s | (junk & ~m);
    dstIn = isMem ? junk : (d | (junk & ~m));
    memWord = d | (junk & ~m);
    start = 1'b1;
    @(negedge clk);
    chk("R10", "busy after accept", {31'd0, busy}, 32'd1);
    // keep start asserted with other operands: must be ignored (R10)
    opKind = ~kind; modrm = ~rm; accIn = ~accIn; srcIn = junk; dstIn = ~junk;
    @(negedge clk);
    start = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (done) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    chk("R10", "done seen", {31'd0, seen}, 32'd1);
    if (seen) begin
      chk("R2", "memory reads", 32'(readCount), isMem ? 32'd1 : 32'd0);
      chk("R7", "read before write", {31'd0, orderBad}, 32'd0);
      chk("R9", "cycle count", {24'd0, cycleCount}, {24'd0, expCyc});
      chk(kind ? "R6" : "R5", "flags", {26'd0, flagsOut}, {26'd0, expFlags});
      chk("R1", "flags enable", {31'd0, flagsWe}, 32'd1);
      if (kind) begin
        chk("R6", "dst we", {31'd0, dstWe}, {31'd0, !isMem});
        if (!isMem) chk("R8", "dst sum", dstData, expDst);
        chk("R6", "src we", {31'd0, srcWe}, 32'd1);
        chk("R8", "src old dst", srcData, d);
        chk("R6", "acc we", {31'd0, accWe}, 32'd0);
        chk("R7", "mem writes", 32'(writeCount), isMem ? 32'd1 : 32'd0);
        if (isMem) chk("R7", "mem write sum", lastWrite, expDst);
      end else if (eq) begin
        chk("R3", "dst we", {31'd0, dstWe}, {31'd0, !isMem});
        if (!isMem) chk("R3", "dst gets src", dstData, expDst);
        chk("R3", "acc we", {31'd0, accWe}, 32'd0);
        chk("R3", "src we", {31'd0, srcWe}, 32'd0);
        chk("R3", "mem writes", 32'(writeCount), isMem ? 32'd1 : 32'd0);
        if (isMem) chk("R3", "mem write src", lastWrite, expDst);
      end else begin
        chk("R4", "dst we", {31'd0, dstWe}, 32'd0);
        chk("R4", "acc we", {31'd0, accWe}, 32'd1);
        chk("R4", "acc gets dst", accData, expAcc);
        chk("R4", "mem writes", 32'(writeCount), 32'd0);
      end
      @(negedge clk);
      chk("R10", "idle after done", {30'd0, busy, done}, 32'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCount++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; opKind = 1'b0; opSize = 2'd0; modrm = 8'hC0;
    accIn = '0; srcIn = '0; dstIn = '0;
    repeat (3) @(negedge clk);
    chk("R1", "busy/done in reset", {30'd0, busy, done}, 32'd0);
    chk("R1", "mem req in reset", {30'd0, memReq, memWe}, 32'd0);
    chk("R1", "writebacks in reset", {28'd0, dstWe, srcWe, accWe, flagsWe}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle after reset", {28'd0, busy, done, memReq, dstWe}, 32'd0);

    for (int k = 0; k < 2; k++) begin
      for (int z = 0; z < 4; z++) begin
        for (int mm = 0; mm < 2; mm++) begin
          for (int i = 0; i < 12; i++) begin
            logic [31:0] msk, top, dv, sv, av;
            logic [7:0]  rm;
            int n;
            n   = (z == 0) ? 8 : (z == 1) ? 16 : 32;
            msk = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1);
            top = 32'd1 << (n - 1);
            lfsr = nextRand(lfsr); dv = lfsr;
            lfsr = nextRand(lfsr); sv = lfsr;
            lfsr = nextRand(lfsr); av = lfsr;
            case (i)
              0: begin dv = msk;      sv = 32'd1; end
              1: begin dv = msk >> 1; sv = 32'd1; av = top; end
              2: begin dv = 32'd0;    sv = 32'd0; end
              3: begin dv = top;      sv = top; end
              4: begin dv = 32'd1;    sv = msk; end
              5: begin av = 32'd0;    dv = 32'd1; end
              default: ;
            endcase
            if (i % 2 == 0) av = dv;
            // mode field boundary: 0xBF memory, 0xC0 register
            rm = mm[0] ? ((i == 0) ? 8'hBF : 8'(i * 7)) : ((i == 0) ? 8'hC0 : (8'hC0 | 8'(i)));
            memLat = i % 3;
            lfsr = nextRand(lfsr);
            runOp(k[0], z[1:0], mm[0], av, sv, dv, rm, lfsr);
          end
        end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

endmodule